// File: doc/BRIEF.md
# Externally Clocked Serial Byte Receiver

This block takes in one byte at a time from an outside device. That device drives its own bit clock and a data line. Both inputs are asynchronous to the system clock. Each rising edge of the outside bit clock adds one data bit to an internal register, and the CPU does nothing per bit. After eight such edges, the block sets a completion flag. When interrupts are enabled, that flag drives an active-low interrupt line.

Both lines pass through a retiming pipeline clocked on the rising edge of the system clock. All shift, count and flag state changes only on the falling edge. Because of this, an asynchronous bit-clock edge can never arrive at the same moment as the edge on which the block acts.

The CPU reads the byte from `rx_byte` and pulses `rd_strobe`. That pulse clears the flag and restarts the bit count. The data path has no back-pressure, because the outside clock cannot be stalled. A byte that is not read before more pulses arrive is shifted further. Reading is therefore the only form of flow control.

Top module: `ext_shift_rx`

## Requirements
- R1: While `rst_n` is low and after it is released, `rx_byte` is all zeros and `irq_n` is high.
- R2: Each accepted bit-clock rise shifts `rx_byte` one place toward bit 7 and puts the `ext_bdat` value into bit 0. The first of eight bits therefore ends in bit 7.
- R3: Suppose a rising edge of `ext_bclk` is set up before system-clock rising edge k. Then `rx_byte` is unchanged after the falling edge that follows edge k, and it shifts at the falling edge that follows edge k+1. `ext_bdat` is sampled with the same alignment.
- R4: Holding `ext_bclk` high, and a falling edge of `ext_bclk`, leave `rx_byte` unchanged, even while `ext_bdat` toggles.
- R5: The eighth shift since reset or since the last read sets the flag. `irq_n` is low exactly while the flag and `irq_en` are both 1.
- R6: With `irq_en` low, `irq_n` stays high. The flag is kept, so raising `irq_en` again drives `irq_n` low with no further shift.
- R7: A `rd_strobe` pulse seen on a falling edge clears the flag and resets the bit count to zero. Eight more shifts are then needed to set the flag again.
- R8: After a byte completes, further pulses keep shifting `rx_byte`, and the flag stays set until a read.
- R9: When a read and a shift fall on the same falling edge, the flag is cleared and that shift counts as the first bit of the next byte. The seventh shift after it sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; retiming on the rising edge, state on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_bclk | input | 1 | Bit clock from the outside device, asynchronous |
| ext_bdat | input | 1 | Serial data from the outside device, held stable around each bit-clock rise |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | CPU read of the received byte; clears the flag and the count |
| rx_byte | output | DATA_W | Received byte register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A byte of alternating and clustered bits shows the entry order and the final bit placement. A single pulse, timed against the system clock, separates the correct two-stage latency from a pipeline one stage short or one stage long.

A long high level and a falling edge, both with the data line toggling, reveal any level-sensitive or both-edge shifting. Reads are placed in three spots: mid-byte, after completion, and on the same edge as a shift. These separate a counter that is reset from one that is not, and read-first priority from shift-first priority. Toggling the enable while the flag is set shows whether the flag is stored separately from the interrupt line.

// File: rtl/shrx_pkg.sv
package shrx_pkg;
  typedef struct packed {
    logic bclk;
    logic bdat;
  } line_pair_t;
endpackage

// File: rtl/edge_retime.sv
module edge_retime
  import shrx_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_bclk,
  input  logic ext_bdat,
  output logic rise,
  output logic dat_s
);
  localparam int unsigned LAST = STAGES - 1;

  line_pair_t pipe [STAGES];
  logic       prev_lvl;

  // stage 0 captures the raw lines on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= '{bclk: ext_bclk, bdat: ext_bdat};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= pipe[g-1];
    end
  end

  // level seen at the previous falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= pipe[LAST].bclk;
  end

  assign rise  = pipe[LAST].bclk & ~prev_lvl;
  assign dat_s = pipe[LAST].bdat;
endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              din,
  output logic [DATA_W-1:0] q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (step) q <= {q[DATA_W-2:0], din};
  end

  AST_HOLD_IDLE: assert property (@(negedge clk) disable iff (!rst_n)
    !step |=> $stable(q)); // R4
  AST_LSB_ENTRY: assert property (@(negedge clk) disable iff (!rst_n)
    step |=> q[0] == $past(din)); // R2
  AST_MOVE_UP: assert property (@(negedge clk) disable iff (!rst_n)
    step |=> q[DATA_W-1:1] == $past(q[DATA_W-2:0])); // R2
endmodule

// File: rtl/byte_counter.sv
module byte_counter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  output logic flag
);
  localparam int unsigned CW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic          wrap;

  // a read restarts the count before the same-edge shift is counted
  assign base = clr ? '0 : cnt;
  assign wrap = step && (base == LAST_BIT);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : base + CW'(step);
      flag <= wrap ? 1'b1 : (clr ? 1'b0 : flag);
    end
  end

  AST_FLAG_NEEDS_SHIFT: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(step)); // R5
  AST_READ_CLEARS: assert property (@(negedge clk) disable iff (!rst_n)
    clr && !step |=> !flag); // R7
endmodule

// File: rtl/ext_shift_rx.sv
module ext_shift_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_bclk,
  input  logic              ext_bdat,
  input  logic              irq_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              irq_n
);
  logic rise;
  logic dat_s;
  logic flag;

  edge_retime #(.STAGES(SYNC_STAGES)) u_retime (
    .clk(clk), .rst_n(rst_n), .ext_bclk(ext_bclk), .ext_bdat(ext_bdat),
    .rise(rise), .dat_s(dat_s)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(rise), .din(dat_s), .q(rx_byte)
  );

  byte_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(rise), .clr(rd_strobe), .flag(flag)
  );

  assign irq_n = ~(flag & irq_en);

  AST_MASK_HOLDS_FLAG: assert property (@(negedge clk) disable iff (!rst_n)
    !irq_en && !rd_strobe && flag |=> flag); // R6
endmodule

// File: tb/ext_shift_rx_test.sv
module ext_shift_rx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, bdat = 1'b0, en = 1'b0, rd = 1'b0;
  logic [7:0] q;
  logic irq_n;
  int vectors = 0, errors = 0;
  bit finished = 0;

  ext_shift_rx uut (.clk(clk), .rst_n(rst_n), .ext_bclk(bclk), .ext_bdat(bdat),
    .irq_en(en), .rd_strobe(rd), .rx_byte(q), .irq_n(irq_n));

  always #2 clk = ~clk;

  // reference model: line history per rising edge, state per falling edge
  bit hc[$] = '{0, 0, 0};
  bit hd[$] = '{0, 0, 0};
  logic [7:0] m_q = 0;
  int m_cnt = 0;
  bit m_flag = 0;

  always @(posedge clk) begin
    hc.push_back(rst_n ? bclk : 1'b0);
    hd.push_back(rst_n ? bdat : 1'b0);
    if (hc.size() > 8) begin void'(hc.pop_front()); void'(hd.pop_front()); end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_q = 0; m_cnt = 0; m_flag = 0;
    end else begin
      bit r;
      r = hc[hc.size()-2] && !hc[hc.size()-3];
      if (rd) begin m_cnt = 0; m_flag = 0; end
      if (r) begin
        m_q = {m_q[6:0], hd[hd.size()-2]};
        m_cnt++;
        if (m_cnt == 8) begin m_cnt = 0; m_flag = 1; end
      end
    end
    #1;
    check("R2 R3 rx_byte", q, m_q);
    check("R5 irq_n", {7'b0, irq_n}, {7'b0, !(m_flag && en)});
  end

  task automatic send_bit(input bit b, input bit rd_sync);
    @(posedge clk); #1; bdat = b; bclk = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1; if (rd_sync) rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0; bclk = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b0);
  endtask

  task automatic read_pulse();
    @(posedge clk); #1; rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    repeat (4) @(posedge clk);
    at_neg(); check("R1 reset byte", q, 8'h00);
    check("R1 reset irq", {7'b0, irq_n}, 8'h01);
    @(posedge clk); #1; rst_n = 1'b1;
    at_neg(); check("R1 after release", q, 8'h00);
    en = 1'b1;

    send_byte(8'hA5);
    at_neg(); check("R2 byte A5", q, 8'hA5);
    check("R5 irq after 8", {7'b0, irq_n}, 8'h00);

    en = 1'b0; at_neg(); check("R6 masked", {7'b0, irq_n}, 8'h01);
    en = 1'b1; at_neg(); check("R6 unmasked", {7'b0, irq_n}, 8'h00);

    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    at_neg(); check("R8 keep shifting", q, 8'h96);
    check("R8 flag stays", {7'b0, irq_n}, 8'h00);

    read_pulse(); at_neg(); check("R7 read clears", {7'b0, irq_n}, 8'h01);

    // R7 counter restart: 3 bits, read, then 8 more needed
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    read_pulse();
    for (int i = 0; i < 7; i++) send_bit(i[0], 1'b0);
    at_neg(); check("R7 seven after read", {7'b0, irq_n}, 8'h01);
    send_bit(1'b1, 1'b0);
    at_neg(); check("R7 eighth after read", {7'b0, irq_n}, 8'h00);
    check("R2 pattern", q, 8'h55);
    read_pulse();

    // R3 latency of a single rise
    @(posedge clk); #1; snap = q; bdat = 1'b1; bclk = 1'b1;
    at_neg(); check("R3 edge N0", q, snap);
    at_neg(); check("R3 edge N1", q, snap);
    at_neg(); check("R3 edge N2", q, {snap[6:0], 1'b1});

    // R4 hold high with toggling data, then fall
    snap = {snap[6:0], 1'b1};
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1; bdat = ~bdat; end
    at_neg(); check("R4 held high", q, snap);
    @(posedge clk); #1; bclk = 1'b0;
    repeat (4) @(posedge clk);
    at_neg(); check("R4 falling edge", q, snap);

    // R9 read on the same edge as a shift
    read_pulse();
    send_bit(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
    at_neg(); check("R9 six after", {7'b0, irq_n}, 8'h01);
    send_bit(1'b0, 1'b0);
    at_neg(); check("R9 seventh after", {7'b0, irq_n}, 8'h00);
    check("R9 byte", q, 8'h7E);

    repeat (4) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule